// File: doc/BRIEF.md
# Interrupt-Enable and Recoverability Control

This block keeps two control bits of a processor state word: the external-interrupt enable (EE) and the recoverable-interrupt flag (RI). It also saves and restores that word around exceptions. The rest of the state word is held here too but is only loaded and saved as a whole. Software changes EE and RI through three reserved special-register numbers. A write of any data to one of them applies a fixed EE/RI pattern. A read of any of them is refused and turns into a request for an unimplemented-instruction trap.

When an exception is taken, the block captures the return address in a saved-PC register and the pre-exception state word in a saved-state register. It then clears EE and RI in the live word. The saved RI bit therefore tells the handler whether the interrupted code was in a point it can resume from. A return-from-exception strobe copies the saved-state register back into the live word. An external-interrupt gate forwards the request only while EE is set and no exception entry is under way in the same cycle.

Every output is registered. A request presented in cycle N is visible after the clock edge that ends cycle N. The instruction decoder and the exception prioritiser sit outside the block. The prioritiser delivers at most one exception-entry strobe per cycle.

Top module: `irq_state_ctl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, EE, RI, the state word, the saved-PC and saved-state registers, the forwarded interrupt and the trap request are all zero.
- R2: A write request to special-register number 80 sets EE=1 and RI=1 whatever its data. EE sits at bit 15 and RI at bit 1 of the state word. All other bits are unchanged.
- R3: A write request to number 81 sets EE=0 and RI=1 whatever its data. Other bits are unchanged.
- R4: A write request to number 82 sets EE=0 and RI=0 whatever its data. Other bits are unchanged.
- R5: A write request to any other special-register number leaves the state word, saved-PC and saved-state registers unchanged.
- R6: A read request to number 80, 81 or 82 raises the trap request for exactly the next cycle and changes no state. A read of any other number raises no trap.
- R7: An exception-entry strobe loads the saved-PC register with the return address and the saved-state register with the state word as it was before the strobe. It then clears EE and RI and keeps every other bit of the state word.
- R8: Bit 1 of the saved-state register, after an entry, equals the RI value in force when the entry was taken. It is 0 when an exception lands while RI is 0.
- R9: A return-from-exception strobe without an entry strobe replaces the whole state word with the saved-state register.
- R10: The forwarded interrupt is high in cycle N+1 exactly when, in cycle N, the external request is high, EE is 1 and no exception-entry strobe is present.
- R11: In one cycle, precedence runs exception entry first, then return-from-exception, then a general state-word write, then a pseudo-register write. Only the winner updates the state word.
- R12: A general state-word write, when it wins under R11, loads the full word given with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mt_valid | input | 1 | Move-to-special-register request |
| mt_sprn | input | SPRN_W | Target special-register number |
| mt_data | input | XLEN | Write data (ignored for the reserved numbers) |
| mf_valid | input | 1 | Move-from-special-register request |
| mf_sprn | input | SPRN_W | Source special-register number |
| exc_entry | input | 1 | Exception-entry strobe from the prioritiser |
| exc_pc | input | PC_W | Return address captured on entry |
| rfi | input | 1 | Return-from-exception strobe |
| msr_wr | input | 1 | General state-word write |
| msr_wdata | input | XLEN | Data for the general write |
| ext_irq | input | 1 | External interrupt request |
| msr_q | output | XLEN | Live state word |
| msr_ee | output | 1 | Live EE bit |
| msr_ri | output | 1 | Live RI bit |
| srr0_q | output | PC_W | Saved PC |
| srr1_q | output | XLEN | Saved state word |
| ext_irq_fwd | output | 1 | Gated external interrupt |
| unimpl_trap | output | 1 | Unimplemented-instruction trap request |

## Verification
The collision that matters is an exception entry in the same cycle as a change to the state word: a reserved-number write, a return-from-exception or a general write. The external request arriving in that cycle with EE set is part of the same case. The bench raises the entry strobe together with each of these in turn. It then expects the saved-state register to hold the word from before that cycle, EE and RI to be cleared, and the forwarded interrupt to stay low. A general write paired with a reserved-number write is also driven, to confirm that the general write alone lands.

// File: rtl/irq_state_pkg.sv
package irq_state_pkg;

  // Action requested through the reserved special-register numbers
  typedef enum logic [1:0] {
    PS_NONE     = 2'd0,
    PS_ALL_ON   = 2'd1,
    PS_EE_OFF   = 2'd2,
    PS_NO_RECOV = 2'd3
  } pseudo_op_e;

  // Which source feeds the live state word this cycle
  typedef enum logic [2:0] {
    SRC_HOLD   = 3'd0,
    SRC_ENTRY  = 3'd1,
    SRC_RETURN = 3'd2,
    SRC_WRITE  = 3'd3,
    SRC_PSEUDO = 3'd4
  } word_src_e;

endpackage

// File: rtl/pseudo_spr_decode.sv
module pseudo_spr_decode
  import irq_state_pkg::*;
#(
  parameter int SPRN_W      = 10,
  parameter int XLEN        = 32,
  parameter int SPR_ALL_ON  = 80,
  parameter int SPR_EE_OFF  = 81,
  parameter int SPR_NO_REC  = 82
) (
  input  logic              mt_valid,
  input  logic [SPRN_W-1:0] mt_sprn,
  input  logic [XLEN-1:0]   mt_data,
  input  logic              mf_valid,
  input  logic [SPRN_W-1:0] mf_sprn,
  output pseudo_op_e        op,
  output logic              mf_hit
);

  localparam logic [SPRN_W-1:0] N_ON  = SPRN_W'(SPR_ALL_ON);
  localparam logic [SPRN_W-1:0] N_OFF = SPRN_W'(SPR_EE_OFF);
  localparam logic [SPRN_W-1:0] N_NR  = SPRN_W'(SPR_NO_REC);

  // Reserved numbers act on the number alone; the data word is dropped.
  logic data_unused;
  assign data_unused = ^mt_data;

  function automatic logic is_reserved(input logic [SPRN_W-1:0] n);
    return (n == N_ON) || (n == N_OFF) || (n == N_NR);
  endfunction

  always_comb begin
    op = PS_NONE;
    if (mt_valid) begin
      unique case (mt_sprn)
        N_ON:    op = PS_ALL_ON;
        N_OFF:   op = PS_EE_OFF;
        N_NR:    op = PS_NO_RECOV;
        default: op = PS_NONE;
      endcase
    end
  end

  assign mf_hit = mf_valid && is_reserved(mf_sprn);

endmodule

// File: rtl/state_word_reg.sv
module state_word_reg
  import irq_state_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int EE_BIT = 15,
  parameter int RI_BIT = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exc_entry,
  input  logic            rfi,
  input  logic [XLEN-1:0] srr1_q,
  input  logic            msr_wr,
  input  logic [XLEN-1:0] msr_wdata,
  input  pseudo_op_e      op,
  output logic [XLEN-1:0] msr_q
);

  word_src_e       src;
  logic            ps_ee, ps_ri;
  logic [XLEN-1:0] nxt;

  // Fixed precedence: entry, return, general write, reserved-number write
  always_comb begin
    if (exc_entry)           src = SRC_ENTRY;
    else if (rfi)            src = SRC_RETURN;
    else if (msr_wr)         src = SRC_WRITE;
    else if (op != PS_NONE)  src = SRC_PSEUDO;
    else                     src = SRC_HOLD;
  end

  always_comb begin
    unique case (op)
      PS_ALL_ON:   begin ps_ee = 1'b1; ps_ri = 1'b1; end
      PS_EE_OFF:   begin ps_ee = 1'b0; ps_ri = 1'b1; end
      PS_NO_RECOV: begin ps_ee = 1'b0; ps_ri = 1'b0; end
      default:     begin ps_ee = 1'b0; ps_ri = 1'b0; end
    endcase
  end

  // Per-bit next value: the two control positions get their own rules
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    if (i == EE_BIT || i == RI_BIT) begin : g_ctl
      logic ps_val;
      assign ps_val = (i == EE_BIT) ? ps_ee : ps_ri;
      always_comb begin
        unique case (src)
          SRC_ENTRY:  nxt[i] = 1'b0;
          SRC_RETURN: nxt[i] = srr1_q[i];
          SRC_WRITE:  nxt[i] = msr_wdata[i];
          SRC_PSEUDO: nxt[i] = ps_val;
          default:    nxt[i] = msr_q[i];
        endcase
      end
    end else begin : g_plain
      always_comb begin
        unique case (src)
          SRC_RETURN: nxt[i] = srr1_q[i];
          SRC_WRITE:  nxt[i] = msr_wdata[i];
          default:    nxt[i] = msr_q[i];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) msr_q <= '0;
    else     msr_q <= nxt;
  end

endmodule

// File: rtl/save_pair_reg.sv
module save_pair_reg #(
  parameter int XLEN = 32,
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exc_entry,
  input  logic [PC_W-1:0] exc_pc,
  input  logic [XLEN-1:0] msr_q,
  output logic [PC_W-1:0] srr0_q,
  output logic [XLEN-1:0] srr1_q
);

  // The live word is sampled before its own update, so the pre-entry
  // RI lands in the saved copy.
  always_ff @(posedge clk) begin
    if (rst) begin
      srr0_q <= '0;
      srr1_q <= '0;
    end else if (exc_entry) begin
      srr0_q <= exc_pc;
      srr1_q <= msr_q;
    end
  end

endmodule

// File: rtl/event_out_reg.sv
module event_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic ext_irq,
  input  logic ee,
  input  logic exc_entry,
  input  logic mf_hit,
  output logic ext_irq_fwd,
  output logic unimpl_trap
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_irq_fwd <= 1'b0;
      unimpl_trap <= 1'b0;
    end else begin
      ext_irq_fwd <= ext_irq && ee && !exc_entry;
      unimpl_trap <= mf_hit;
    end
  end

endmodule

// File: rtl/irq_state_ctl.sv
module irq_state_ctl
  import irq_state_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int PC_W       = 32,
  parameter int SPRN_W     = 10,
  parameter int EE_BIT     = 15,
  parameter int RI_BIT     = 1,
  parameter int SPR_ALL_ON = 80,
  parameter int SPR_EE_OFF = 81,
  parameter int SPR_NO_REC = 82
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mt_valid,
  input  logic [SPRN_W-1:0] mt_sprn,
  input  logic [XLEN-1:0]   mt_data,
  input  logic              mf_valid,
  input  logic [SPRN_W-1:0] mf_sprn,
  input  logic              exc_entry,
  input  logic [PC_W-1:0]   exc_pc,
  input  logic              rfi,
  input  logic              msr_wr,
  input  logic [XLEN-1:0]   msr_wdata,
  input  logic              ext_irq,
  output logic [XLEN-1:0]   msr_q,
  output logic              msr_ee,
  output logic              msr_ri,
  output logic [PC_W-1:0]   srr0_q,
  output logic [XLEN-1:0]   srr1_q,
  output logic              ext_irq_fwd,
  output logic              unimpl_trap
);

  pseudo_op_e op;
  logic       mf_hit;

  pseudo_spr_decode #(
    .SPRN_W(SPRN_W), .XLEN(XLEN),
    .SPR_ALL_ON(SPR_ALL_ON), .SPR_EE_OFF(SPR_EE_OFF), .SPR_NO_REC(SPR_NO_REC)
  ) u_dec (
    .mt_valid(mt_valid), .mt_sprn(mt_sprn), .mt_data(mt_data),
    .mf_valid(mf_valid), .mf_sprn(mf_sprn),
    .op(op), .mf_hit(mf_hit)
  );

  state_word_reg #(.XLEN(XLEN), .EE_BIT(EE_BIT), .RI_BIT(RI_BIT)) u_word (
    .clk(clk), .rst(rst), .exc_entry(exc_entry), .rfi(rfi),
    .srr1_q(srr1_q), .msr_wr(msr_wr), .msr_wdata(msr_wdata),
    .op(op), .msr_q(msr_q)
  );

  save_pair_reg #(.XLEN(XLEN), .PC_W(PC_W)) u_save (
    .clk(clk), .rst(rst), .exc_entry(exc_entry), .exc_pc(exc_pc),
    .msr_q(msr_q), .srr0_q(srr0_q), .srr1_q(srr1_q)
  );

  event_out_reg u_evt (
    .clk(clk), .rst(rst), .ext_irq(ext_irq), .ee(msr_q[EE_BIT]),
    .exc_entry(exc_entry), .mf_hit(mf_hit),
    .ext_irq_fwd(ext_irq_fwd), .unimpl_trap(unimpl_trap)
  );

  assign msr_ee = msr_q[EE_BIT];
  assign msr_ri = msr_q[RI_BIT];

endmodule

// File: rtl/irq_state_ctl_chk.sv
module irq_state_ctl_chk #(
  parameter int XLEN       = 32,
  parameter int PC_W       = 32,
  parameter int SPRN_W     = 10,
  parameter int EE_BIT     = 15,
  parameter int RI_BIT     = 1,
  parameter int SPR_ALL_ON = 80,
  parameter int SPR_EE_OFF = 81,
  parameter int SPR_NO_REC = 82
) (
  input logic              clk,
  input logic              rst,
  input logic              mt_valid,
  input logic [SPRN_W-1:0] mt_sprn,
  input logic              mf_valid,
  input logic [SPRN_W-1:0] mf_sprn,
  input logic              exc_entry,
  input logic [PC_W-1:0]   exc_pc,
  input logic              rfi,
  input logic              msr_wr,
  input logic [XLEN-1:0]   msr_wdata,
  input logic              ext_irq,
  input logic [XLEN-1:0]   msr_q,
  input logic              msr_ee,
  input logic              msr_ri,
  input logic [PC_W-1:0]   srr0_q,
  input logic [XLEN-1:0]   srr1_q,
  input logic              ext_irq_fwd,
  input logic              unimpl_trap
);

  localparam logic [SPRN_W-1:0] N_ON  = SPRN_W'(SPR_ALL_ON);
  localparam logic [SPRN_W-1:0] N_OFF = SPRN_W'(SPR_EE_OFF);
  localparam logic [SPRN_W-1:0] N_NR  = SPRN_W'(SPR_NO_REC);

  logic quiet, mf_res;
  assign quiet  = !exc_entry && !rfi && !msr_wr;
  assign mf_res = mf_valid && (mf_sprn == N_ON || mf_sprn == N_OFF || mf_sprn == N_NR);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (msr_q == '0 && srr0_q == '0 && srr1_q == '0 && !ext_irq_fwd && !unimpl_trap));

  p_all_on_r2: assert property (@(posedge clk) disable iff (rst)
    (quiet && mt_valid && mt_sprn == N_ON) |=> (msr_ee && msr_ri));

  p_ee_off_r3: assert property (@(posedge clk) disable iff (rst)
    (quiet && mt_valid && mt_sprn == N_OFF) |=> (!msr_ee && msr_ri));

  p_no_recov_r4: assert property (@(posedge clk) disable iff (rst)
    (quiet && mt_valid && mt_sprn == N_NR) |=> (!msr_ee && !msr_ri));

  p_other_spr_r5: assert property (@(posedge clk) disable iff (rst)
    (quiet && !(mt_valid && (mt_sprn == N_ON || mt_sprn == N_OFF || mt_sprn == N_NR)))
      |=> $stable(msr_q));

  p_trap_hit_r6: assert property (@(posedge clk) disable iff (rst)
    mf_res |=> unimpl_trap);

  p_trap_miss_r6: assert property (@(posedge clk) disable iff (rst)
    !mf_res |=> !unimpl_trap);

  p_entry_r7: assert property (@(posedge clk) disable iff (rst)
    exc_entry |=> (!msr_ee && !msr_ri && srr0_q == $past(exc_pc) && srr1_q == $past(msr_q)));

  p_saved_ri_r8: assert property (@(posedge clk) disable iff (rst)
    exc_entry |=> (srr1_q[RI_BIT] == $past(msr_ri)));

  p_return_r9: assert property (@(posedge clk) disable iff (rst)
    (rfi && !exc_entry) |=> (msr_q == $past(srr1_q)));

  p_gate_entry_r10: assert property (@(posedge clk) disable iff (rst)
    exc_entry |=> !ext_irq_fwd);

  p_gate_need_ee_r10: assert property (@(posedge clk) disable iff (rst)
    (!msr_ee || !ext_irq) |=> !ext_irq_fwd);

  p_write_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (msr_wr && !exc_entry && !rfi) |=> (msr_q == $past(msr_wdata)));

endmodule

bind irq_state_ctl irq_state_ctl_chk #(
  .XLEN(XLEN), .PC_W(PC_W), .SPRN_W(SPRN_W), .EE_BIT(EE_BIT), .RI_BIT(RI_BIT),
  .SPR_ALL_ON(SPR_ALL_ON), .SPR_EE_OFF(SPR_EE_OFF), .SPR_NO_REC(SPR_NO_REC)
) u_chk (
  .clk(clk), .rst(rst), .mt_valid(mt_valid), .mt_sprn(mt_sprn),
  .mf_valid(mf_valid), .mf_sprn(mf_sprn), .exc_entry(exc_entry), .exc_pc(exc_pc),
  .rfi(rfi), .msr_wr(msr_wr), .msr_wdata(msr_wdata), .ext_irq(ext_irq),
  .msr_q(msr_q), .msr_ee(msr_ee), .msr_ri(msr_ri), .srr0_q(srr0_q), .srr1_q(srr1_q),
  .ext_irq_fwd(ext_irq_fwd), .unimpl_trap(unimpl_trap)
);

// File: tb/irq_state_ctl_test.sv
module irq_state_ctl_test;

  localparam int EEB = 15;
  localparam int RIB = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mt_valid = 1'b0, mf_valid = 1'b0, exc_entry = 1'b0;
  logic        rfi = 1'b0, msr_wr = 1'b0, ext_irq = 1'b0;
  logic [9:0]  mt_sprn = '0, mf_sprn = '0;
  logic [31:0] mt_data = '0, exc_pc = '0, msr_wdata = '0;
  logic [31:0] msr_q, srr0_q, srr1_q;
  logic        msr_ee, msr_ri, ext_irq_fwd, unimpl_trap;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;  // 250 MHz

  irq_state_ctl uut (
    .clk(clk), .rst(rst), .mt_valid(mt_valid), .mt_sprn(mt_sprn), .mt_data(mt_data),
    .mf_valid(mf_valid), .mf_sprn(mf_sprn), .exc_entry(exc_entry), .exc_pc(exc_pc),
    .rfi(rfi), .msr_wr(msr_wr), .msr_wdata(msr_wdata), .ext_irq(ext_irq),
    .msr_q(msr_q), .msr_ee(msr_ee), .msr_ri(msr_ri), .srr0_q(srr0_q), .srr1_q(srr1_q),
    .ext_irq_fwd(ext_irq_fwd), .unimpl_trap(unimpl_trap)
  );

  typedef struct {
    logic [31:0] msr;
    logic [31:0] s0;
    logic [31:0] s1;
    logic        fwd;
    logic        trap;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  // Bench-side model of the requirements
  logic [31:0] m_msr = '0, m_s0 = '0, m_s1 = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv,
                       input string what);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Monitor: one registered result per driven cycle, read after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, msr_q, e.msr, "state");
      check(e.tag, srr0_q, e.s0, "srr0");
      check(e.tag, srr1_q, e.s1, "srr1");
      check(e.tag, {31'd0, msr_ee}, {31'd0, e.msr[EEB]}, "ee");
      check(e.tag, {31'd0, msr_ri}, {31'd0, e.msr[RIB]}, "ri");
      check(e.tag, {31'd0, ext_irq_fwd}, {31'd0, e.fwd}, "fwd");
      check(e.tag, {31'd0, unimpl_trap}, {31'd0, e.trap}, "trap");
    end
  end

  task automatic drive(input logic mtv, input int mtn, input logic [31:0] mtd,
                       input logic mfv, input int mfn, input logic ex,
                       input logic [31:0] pc, input logic rf, input logic wr,
                       input logic [31:0] wd, input logic irq, input string tag);
    exp_t e;
    @(negedge clk);
    mt_valid = mtv; mt_sprn = 10'(mtn); mt_data = mtd;
    mf_valid = mfv; mf_sprn = 10'(mfn); exc_entry = ex; exc_pc = pc;
    rfi = rf; msr_wr = wr; msr_wdata = wd; ext_irq = irq;
    e.fwd  = irq && m_msr[EEB] && !ex;
    e.trap = mfv && (mfn == 80 || mfn == 81 || mfn == 82);
    if (ex) begin
      m_s0 = pc; m_s1 = m_msr; m_msr[EEB] = 1'b0; m_msr[RIB] = 1'b0;
    end else if (rf) begin
      m_msr = m_s1;
    end else if (wr) begin
      m_msr = wd;
    end else if (mtv) begin
      case (mtn)
        80: begin m_msr[EEB] = 1'b1; m_msr[RIB] = 1'b1; end
        81: begin m_msr[EEB] = 1'b0; m_msr[RIB] = 1'b1; end
        82: begin m_msr[EEB] = 1'b0; m_msr[RIB] = 1'b0; end
        default: ;
      endcase
    end
    e.msr = m_msr; e.s0 = m_s0; e.s1 = m_s1; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic mt(input int n, input logic [31:0] d, input string tag);
    drive(1, n, d, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic mf(input int n, input string tag);
    drive(0, 0, 0, 1, n, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic take(input logic [31:0] pc, input string tag);
    drive(0, 0, 0, 0, 0, 1, pc, 0, 0, 0, 0, tag);
  endtask

  initial begin : wdog
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", msr_q, 32'h0, "state in reset");
    check("R1", srr0_q | srr1_q, 32'h0, "saved in reset");
    check("R1", {30'd0, ext_irq_fwd, unimpl_trap}, 32'h0, "outputs in reset");
    @(negedge clk); rst = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R1");
    mt(80, 32'h0, "R2");
    mt(82, 32'hFFFF_FFFF, "R4");
    mt(81, 32'h0001_2345, "R3");
    mt(80, 32'hA5A5_A5A5, "R2");
    mt(100, 32'hFFFF_FFFF, "R5");
    mt(79, 32'h0, "R5");
    mt(83, 32'h0, "R5");
    mf(80, "R6"); mf(81, "R6"); mf(82, "R6");
    mf(83, "R6"); mf(79, "R6");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_8042, 0, "R12");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
    mt(81, 32'h0, "R3");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
    mt(80, 32'h0, "R2");
    take(32'h0000_1000, "R7");
    take(32'h0000_2004, "R8");
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R9");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hF000_8002, 0, "R12");
    take(32'h0000_3000, "R8");
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R9");
    drive(1, 80, 32'h0, 0, 0, 1, 32'h0000_4000, 0, 0, 0, 1, "R11");
    mt(80, 32'h0, "R2");
    drive(0, 0, 0, 0, 0, 1, 32'h0000_5000, 1, 1, 32'hFFFF_FFFF, 1, "R11");
    drive(1, 80, 32'h0, 0, 0, 0, 0, 0, 1, 32'h0000_0100, 0, "R11");
    drive(1, 80, 32'h0, 0, 0, 0, 0, 1, 1, 32'h0000_0200, 0, "R11");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule